// File: doc/BRIEF.md
# Indirect Addressing Pointer Unit

This block keeps three 12-bit data-memory pointers. It turns an access to a small set of virtual operand registers into a real data-memory address. A processor core presents an 8-bit operand address with either a read strobe or a write strobe. The block first forms the direct 12-bit address from that operand address.

If the direct address lands on one of the virtual operands, the access is indirect. The effective address then comes from the chosen pointer, and that pointer may be stepped at the clock edge. The five operand types are plain, post-decrement, post-increment, pre-increment, and offset by the signed working register. Each one orders its use and its modification in its own way.

Pointer halves can be written and read back byte by byte. A data-memory read and write strobe pair is driven alongside the effective address. The strobe is suppressed when an indirect access points back at the virtual operands themselves. No status flags are produced or altered by any pointer arithmetic.

Top module: `indptr_unit`

## Requirements
- R1: After reset all three pointers are 000h. A write to a pointer's high byte keeps only bits 3:0 of the data. A readback of the high byte returns bits 7:4 as zero (selector 0..2 picks the pointer; `ptr_rhi`=1 selects the high byte).
- R2: The plain operand (slot 0) puts the selected pointer on `eff_addr` and leaves that pointer unchanged.
- R3: The post-decrement operand (slot 1) puts the current pointer on `eff_addr` and decrements the pointer by one at the clock edge.
- R4: The post-increment operand (slot 2) puts the current pointer on `eff_addr` and increments the pointer by one at the clock edge.
- R5: The pre-increment operand (slot 3) puts pointer+1 on `eff_addr` in the same cycle, and the pointer becomes that value at the clock edge.
- R6: The offset operand (slot 4) puts the pointer plus the sign-extended `wreg` (modulo 4096) on `eff_addr` and leaves the pointer unchanged.
- R7: Stepping works on the whole 12-bit pointer. Low-byte carry and borrow propagate into the high nibble, and FFFh+1 wraps to 000h while 000h-1 wraps to FFFh.
- R8: Virtual operand slot k of pointer p sits at direct address FD0h + 8·p + k, with k in 0..4. Once an access is recognised as indirect, `bank_reg` and `acc_bank_sel` have no effect on `eff_addr`.
- R9: An indirect access whose effective address is itself a virtual operand address drives neither `mem_re` nor `mem_we`. Such an access does not change the pointer that the effective address designates.
- R10: A direct byte write to a pointer in the same cycle as an auto-modify of that pointer wins. The written byte takes the new data, the other byte keeps its old value, and the step is dropped.
- R11: A non-virtual access gives `ind_access`=0, and `eff_addr` is the direct address. With `acc_bank_sel`=1 the direct address is {bank_reg, acc_addr}. With `acc_bank_sel`=0, an `acc_addr` below 80h maps to 0xx and one at 80h or above maps to Fxx. In this case `mem_re` and `mem_we` follow `acc_rd` and `acc_wr`, and no pointer changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_addr | input | 8 | Operand address of the access |
| acc_bank_sel | input | 1 | 1: use bank_reg; 0: access-bank mapping |
| bank_reg | input | 4 | Bank number for banked direct addressing |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| wreg | input | 8 | Working register value (signed offset) |
| ptr_we | input | 1 | Direct pointer byte write enable |
| ptr_wsel | input | 2 | Pointer chosen for the byte write |
| ptr_whi | input | 1 | 1: write high byte, 0: low byte |
| ptr_wdata | input | 8 | Byte write data |
| ptr_rsel | input | 2 | Pointer chosen for readback |
| ptr_rhi | input | 1 | 1: read high byte, 0: low byte |
| ptr_rdata | output | 8 | Readback byte |
| eff_addr | output | 12 | Effective data-memory address |
| ind_access | output | 1 | Current access is indirect |
| mem_re | output | 1 | Data-memory read strobe |
| mem_we | output | 1 | Data-memory write strobe |

## Verification
Every operand type is run against each of the three pointers. Some starting values sit mid-range and others sit at byte or range edges (0FFh, 100h, FFFh, 000h). This separates a correct 12-bit step from a low-byte-only step, and shows where the use happens before or after the modify.

The offset operand is driven with positive, negative and wrapping working-register values, which separates sign extension from zero extension. Banked, unbanked and unused-slot addresses tell indirect decoding apart from direct mapping. A pointer aimed at a virtual slot, and a byte write that collides with a step, show that self-reference and the write-over-step priority rule are handled.

// File: rtl/indptr_pkg.sv
package indptr_pkg;
    typedef enum logic [2:0] {
        OP_PLAIN   = 3'd0,
        OP_POSTDEC = 3'd1,
        OP_POSTINC = 3'd2,
        OP_PREINC  = 3'd3,
        OP_OFFSET  = 3'd4
    } op_kind_e;

    localparam int unsigned NUM_KINDS = 5;
endpackage

// File: rtl/indptr_decode.sv
module indptr_decode
    import indptr_pkg::*;
#(
    parameter int unsigned    AW         = 12,
    parameter int unsigned    NPTR       = 3,
    parameter int unsigned    STRIDE_LG2 = 3,
    parameter logic [AW-1:0]  VIRT_BASE  = 12'hFD0,
    localparam int unsigned   SELW       = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic [AW-1:0]   addr,
    output logic            hit,
    output logic [SELW-1:0] sel,
    output op_kind_e        kind
);
    localparam logic [AW-1:0]         SPAN  = AW'(NPTR) << STRIDE_LG2;
    localparam logic [STRIDE_LG2-1:0] KLIM  = STRIDE_LG2'(NUM_KINDS);

    logic [AW-1:0]         off;
    logic [STRIDE_LG2-1:0] kidx;
    logic                  in_rng;

    always_comb begin
        off    = addr - VIRT_BASE;
        in_rng = (addr >= VIRT_BASE) && (off < SPAN);
        kidx   = off[STRIDE_LG2-1:0];
        hit    = in_rng && (kidx < KLIM);
        sel    = SELW'(off >> STRIDE_LG2);
        kind   = op_kind_e'(3'(kidx));
    end
endmodule

// File: rtl/indptr_agen.sv
module indptr_agen
    import indptr_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  op_kind_e       kind,
    input  logic [AW-1:0]  cur,
    input  logic [7:0]     wreg,
    output logic [AW-1:0]  ea,
    output logic [AW-1:0]  nxt,
    output logic           modifies
);
    logic [AW-1:0] sext;
    logic [AW-1:0] inc;
    logic [AW-1:0] dec;

    always_comb begin
        sext     = {{(AW-8){wreg[7]}}, wreg};
        inc      = cur + AW'(1);
        dec      = cur - AW'(1);
        ea       = cur;
        nxt      = cur;
        modifies = 1'b0;
        case (kind)
            OP_POSTDEC: begin nxt = dec; modifies = 1'b1; end
            OP_POSTINC: begin nxt = inc; modifies = 1'b1; end
            OP_PREINC:  begin ea = inc; nxt = inc; modifies = 1'b1; end
            OP_OFFSET:  ea = cur + sext;
            default:    ea = cur;
        endcase
    end
endmodule

// File: rtl/indptr_file.sv
module indptr_file #(
    parameter int unsigned AW   = 12,
    parameter int unsigned NPTR = 3,
    localparam int unsigned SELW = (NPTR > 1) ? $clog2(NPTR) : 1,
    localparam int unsigned HIW  = AW - 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SELW-1:0]          wr_sel,
    input  logic                     wr_hi,
    input  logic [7:0]               wr_data,
    input  logic                     upd_en,
    input  logic [SELW-1:0]          upd_sel,
    input  logic [AW-1:0]            upd_val,
    input  logic [SELW-1:0]          rd_sel,
    input  logic                     rd_hi,
    output logic [NPTR-1:0][AW-1:0]  ptrs,
    output logic [7:0]               rd_data
);
    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] ptr;
    } file_st_t;

    file_st_t st_d, st_q;
    logic [AW-1:0] rd_ptr;

    always_comb begin
        st_d   = st_q;
        rd_ptr = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (wr_en && (wr_sel == SELW'(i))) begin
                if (wr_hi) st_d.ptr[i][AW-1:8] = wr_data[HIW-1:0];
                else       st_d.ptr[i][7:0]    = wr_data;
            end else if (upd_en && (upd_sel == SELW'(i))) begin
                st_d.ptr[i] = upd_val;
            end
            if (rd_sel == SELW'(i)) rd_ptr = st_q.ptr[i];
        end
        rd_data = rd_hi ? 8'(rd_ptr[AW-1:8]) : rd_ptr[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptrs = st_q.ptr;

    // R10
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi && (wr_sel < SELW'(NPTR)))
        |=> (st_q.ptr[$past(wr_sel)][7:0] == $past(wr_data)));

    // R1
    rd_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |-> (rd_data[7:HIW] == '0));
endmodule

// File: rtl/indptr_unit.sv
module indptr_unit
    import indptr_pkg::*;
#(
    parameter int unsigned   AW         = 12,
    parameter int unsigned   NPTR       = 3,
    parameter int unsigned   STRIDE_LG2 = 3,
    parameter logic [AW-1:0] VIRT_BASE  = 12'hFD0,
    localparam int unsigned  SELW       = (NPTR > 1) ? $clog2(NPTR) : 1,
    localparam int unsigned  BKW        = AW - 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      acc_addr,
    input  logic            acc_bank_sel,
    input  logic [BKW-1:0]  bank_reg,
    input  logic            acc_rd,
    input  logic            acc_wr,
    input  logic [7:0]      wreg,
    input  logic            ptr_we,
    input  logic [SELW-1:0] ptr_wsel,
    input  logic            ptr_whi,
    input  logic [7:0]      ptr_wdata,
    input  logic [SELW-1:0] ptr_rsel,
    input  logic            ptr_rhi,
    output logic [7:0]      ptr_rdata,
    output logic [AW-1:0]   eff_addr,
    output logic            ind_access,
    output logic            mem_re,
    output logic            mem_we
);
    logic                    acc_active;
    logic [AW-1:0]           direct_addr;
    logic                    d_hit, t_hit;
    logic [SELW-1:0]         d_sel, t_sel;
    op_kind_e                d_kind, t_kind;
    logic [NPTR-1:0][AW-1:0] ptrs;
    logic [AW-1:0]           cur_ptr;
    logic [AW-1:0]           ind_ea, ind_nxt;
    logic                    ind_mod;
    logic                    upd_en;

    always_comb begin
        acc_active = acc_rd | acc_wr;
        if (acc_bank_sel)     direct_addr = {bank_reg, acc_addr};
        else if (acc_addr[7]) direct_addr = {{BKW{1'b1}}, acc_addr};
        else                  direct_addr = {{BKW{1'b0}}, acc_addr};
        cur_ptr = '0;
        for (int i = 0; i < NPTR; i++)
            if (d_sel == SELW'(i)) cur_ptr = ptrs[i];
    end

    indptr_decode #(.AW(AW), .NPTR(NPTR), .STRIDE_LG2(STRIDE_LG2), .VIRT_BASE(VIRT_BASE))
        op_dec_i (.addr(direct_addr), .hit(d_hit), .sel(d_sel), .kind(d_kind));

    indptr_agen #(.AW(AW))
        agen_i (.kind(d_kind), .cur(cur_ptr), .wreg(wreg),
                .ea(ind_ea), .nxt(ind_nxt), .modifies(ind_mod));

    indptr_decode #(.AW(AW), .NPTR(NPTR), .STRIDE_LG2(STRIDE_LG2), .VIRT_BASE(VIRT_BASE))
        tgt_dec_i (.addr(ind_ea), .hit(t_hit), .sel(t_sel), .kind(t_kind));

    always_comb begin
        ind_access = acc_active && d_hit;
        eff_addr   = d_hit ? ind_ea : direct_addr;
        upd_en     = ind_access && ind_mod;
        mem_re     = acc_rd && !(d_hit && t_hit);
        mem_we     = acc_wr && !(d_hit && t_hit);
    end

    indptr_file #(.AW(AW), .NPTR(NPTR))
        file_i (.clk(clk), .rst_n(rst_n),
                .wr_en(ptr_we), .wr_sel(ptr_wsel), .wr_hi(ptr_whi), .wr_data(ptr_wdata),
                .upd_en(upd_en), .upd_sel(d_sel), .upd_val(ind_nxt),
                .rd_sel(ptr_rsel), .rd_hi(ptr_rhi), .ptrs(ptrs), .rd_data(ptr_rdata));

    // R2
    plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_access && d_kind == OP_PLAIN && !ptr_we)
        |=> (ptrs[$past(d_sel)] == $past(eff_addr)));

    // R3
    postdec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_access && d_kind == OP_POSTDEC && !ptr_we)
        |=> (ptrs[$past(d_sel)] == $past(eff_addr) - AW'(1)));

    // R4
    postinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_access && d_kind == OP_POSTINC && !ptr_we)
        |=> (ptrs[$past(d_sel)] == $past(eff_addr) + AW'(1)));

    // R5
    preinc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_access && d_kind == OP_PREINC && !ptr_we)
        |=> (ptrs[$past(d_sel)] == $past(eff_addr)));

    // R9
    virt_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_access && t_hit) |-> (!mem_re && !mem_we));

    // R11
    direct_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!d_hit) |-> (mem_re == acc_rd && mem_we == acc_wr && !ind_access));
endmodule

// File: tb/indptr_unit_tb.sv
module indptr_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_addr = '0;
    logic       acc_bank_sel = 1'b0;
    logic [3:0] bank_reg = '0;
    logic       acc_rd = 1'b0, acc_wr = 1'b0;
    logic [7:0] wreg = '0;
    logic       ptr_we = 1'b0;
    logic [1:0] ptr_wsel = '0;
    logic       ptr_whi = 1'b0;
    logic [7:0] ptr_wdata = '0;
    logic [1:0] ptr_rsel = '0;
    logic       ptr_rhi = 1'b0;
    logic [7:0] ptr_rdata;
    logic [11:0] eff_addr;
    logic       ind_access, mem_re, mem_we;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [11:0] s_ea;
    logic        s_ind, s_re, s_we;

    always #10 clk = ~clk;

    indptr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_bank_sel(acc_bank_sel),
        .bank_reg(bank_reg), .acc_rd(acc_rd), .acc_wr(acc_wr), .wreg(wreg),
        .ptr_we(ptr_we), .ptr_wsel(ptr_wsel), .ptr_whi(ptr_whi), .ptr_wdata(ptr_wdata),
        .ptr_rsel(ptr_rsel), .ptr_rhi(ptr_rhi), .ptr_rdata(ptr_rdata),
        .eff_addr(eff_addr), .ind_access(ind_access), .mem_re(mem_re), .mem_we(mem_we));

    typedef struct packed {
        logic [1:0]  p;
        logic [2:0]  k;
        logic [11:0] init;
        logic [7:0]  w;
        logic [11:0] ea;
        logic [11:0] nptr;
    } vec_t;

    // k: 0 plain R2, 1 postdec R3, 2 postinc R4, 3 preinc R5, 4 offset R6; edge rows R7
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 12'h123, 8'h00, 12'h123, 12'h123},
        '{2'd1, 3'd1, 12'h100, 8'h00, 12'h100, 12'h0FF},
        '{2'd2, 3'd2, 12'h0FF, 8'h00, 12'h0FF, 12'h100},
        '{2'd0, 3'd3, 12'h2FF, 8'h00, 12'h300, 12'h300},
        '{2'd1, 3'd4, 12'h100, 8'h80, 12'h080, 12'h100},
        '{2'd2, 3'd4, 12'h0F0, 8'h7F, 12'h16F, 12'h0F0},
        '{2'd0, 3'd2, 12'hFFF, 8'h00, 12'hFFF, 12'h000},
        '{2'd1, 3'd1, 12'h000, 8'h00, 12'h000, 12'hFFF},
        '{2'd2, 3'd3, 12'hFFF, 8'h00, 12'h000, 12'h000},
        '{2'd0, 3'd4, 12'hFF0, 8'h20, 12'h010, 12'hFF0},
        '{2'd1, 3'd4, 12'h005, 8'hFB, 12'h000, 12'h005}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [1:0] p, input logic hi, input logic [7:0] d);
        @(negedge clk);
        ptr_we = 1'b1; ptr_wsel = p; ptr_whi = hi; ptr_wdata = d;
        @(negedge clk);
        ptr_we = 1'b0;
    endtask

    task automatic set_ptr(input logic [1:0] p, input logic [11:0] v);
        wr_byte(p, 1'b0, v[7:0]);
        wr_byte(p, 1'b1, {4'h0, v[11:8]});
    endtask

    task automatic read_ptr(input logic [1:0] p, output logic [11:0] v);
        logic [7:0] lo;
        ptr_rsel = p; ptr_rhi = 1'b0; #1; lo = ptr_rdata;
        ptr_rhi = 1'b1; #1;
        v = {ptr_rdata[3:0], lo};
    endtask

    task automatic do_acc(input logic [7:0] a, input logic bs, input logic [3:0] br,
                          input logic rd, input logic wr, input logic [7:0] w);
        @(negedge clk);
        acc_addr = a; acc_bank_sel = bs; bank_reg = br; acc_rd = rd; acc_wr = wr; wreg = w;
        #2;
        s_ea = eff_addr; s_ind = ind_access; s_re = mem_re; s_we = mem_we;
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0;
    endtask

    function automatic string kreq(input logic [2:0] k);
        case (k)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [11:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int p = 0; p < 3; p++) begin
            read_ptr(2'(p), v);
            check("R1", "reset pointer", 32'(v), 32'h0);
        end
        #1;
        check("R11", "idle ind_access", 32'(ind_access), 32'h0);
        check("R11", "idle mem_re", 32'(mem_re), 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            vec_t t = VECS[i];
            set_ptr(t.p, t.init);
            do_acc(8'(8'hD0 + 8 * t.p + t.k), 1'b0, 4'h0, 1'b1, 1'b0, t.w);
            check(kreq(t.k), "ind_access", 32'(s_ind), 32'h1);
            check(kreq(t.k), "eff_addr", 32'(s_ea), 32'(t.ea));
            check(kreq(t.k), "mem_re", 32'(s_re), 32'h1);
            read_ptr(t.p, v);
            check(kreq(t.k), "pointer after", 32'(v), 32'(t.nptr));
        end

        // R1 high byte keeps low nibble only
        wr_byte(2'd2, 1'b1, 8'hAB);
        ptr_rsel = 2'd2; ptr_rhi = 1'b1; #1;
        check("R1", "high byte readback", 32'(ptr_rdata), 32'h0B);

        // R8 bank inputs ignored once indirect
        set_ptr(2'd1, 12'h3C4);
        do_acc(8'hD8, 1'b1, 4'hF, 1'b1, 1'b0, 8'h00);
        check("R8", "banked ind", 32'(s_ind), 32'h1);
        check("R8", "banked ea", 32'(s_ea), 32'h3C4);
        do_acc(8'hD8, 1'b0, 4'h7, 1'b1, 1'b0, 8'h00);
        check("R8", "access-bank ea", 32'(s_ea), 32'h3C4);

        // R11 direct accesses
        do_acc(8'hD8, 1'b1, 4'h3, 1'b1, 1'b0, 8'h00);
        check("R11", "bank3 ind", 32'(s_ind), 32'h0);
        check("R11", "bank3 ea", 32'(s_ea), 32'h3D8);
        check("R11", "bank3 mem_re", 32'(s_re), 32'h1);
        do_acc(8'h40, 1'b0, 4'h9, 1'b0, 1'b1, 8'h00);
        check("R11", "low access ea", 32'(s_ea), 32'h040);
        check("R11", "low access mem_we", 32'(s_we), 32'h1);
        do_acc(8'hD5, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
        check("R11", "unused slot ind", 32'(s_ind), 32'h0);
        check("R11", "unused slot ea", 32'(s_ea), 32'hFD5);
        read_ptr(2'd1, v);
        check("R11", "pointer untouched", 32'(v), 32'h3C4);

        // R9 pointer aimed at a virtual slot
        set_ptr(2'd0, 12'hFD9);
        do_acc(8'hD0, 1'b0, 4'h0, 1'b1, 1'b0, 8'h00);
        check("R9", "self ind", 32'(s_ind), 32'h1);
        check("R9", "self ea", 32'(s_ea), 32'hFD9);
        check("R9", "self mem_re", 32'(s_re), 32'h0);
        do_acc(8'hD0, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00);
        check("R9", "self mem_we", 32'(s_we), 32'h0);
        read_ptr(2'd1, v);
        check("R9", "target pointer unchanged", 32'(v), 32'h3C4);
        set_ptr(2'd0, 12'h200);
        do_acc(8'hD0, 1'b0, 4'h0, 1'b0, 1'b1, 8'h00);
        check("R9", "normal mem_we", 32'(s_we), 32'h1);

        // R10 byte write collides with post-increment
        set_ptr(2'd0, 12'h1FF);
        @(negedge clk);
        ptr_we = 1'b1; ptr_wsel = 2'd0; ptr_whi = 1'b0; ptr_wdata = 8'h55;
        acc_addr = 8'hD2; acc_bank_sel = 1'b0; acc_rd = 1'b1;
        #2;
        check("R10", "collide ea", 32'(eff_addr), 32'h1FF);
        @(negedge clk);
        ptr_we = 1'b0; acc_rd = 1'b0;
        read_ptr(2'd0, v);
        check("R10", "write wins", 32'(v), 32'h155);

        // R10 write to another pointer does not block the step
        set_ptr(2'd2, 12'h010);
        @(negedge clk);
        ptr_we = 1'b1; ptr_wsel = 2'd1; ptr_whi = 1'b0; ptr_wdata = 8'h77;
        acc_addr = 8'hE2; acc_rd = 1'b1;
        @(negedge clk);
        ptr_we = 1'b0; acc_rd = 1'b0;
        read_ptr(2'd2, v);
        check("R10", "other pointer steps", 32'(v), 32'h011);
        read_ptr(2'd1, v);
        check("R10", "written pointer", 32'(v), 32'h377);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule